// File: doc/BRIEF.md
# Four-Slot Memory Paging Unit

This unit lets a CPU with a 16-bit address bus reach a 4 MB physical memory. The CPU address space is cut into four 16 KB slots. Each slot owns an 8-bit page register, and that register picks which 16 KB page of physical memory the slot shows. The top two address bits choose the slot. The low fourteen bits pass through unchanged as the offset inside the page.

The page number also decides what kind of memory the slot holds. Pages 0 and 1 are read-only ROM. Pages 0xFC to 0xFF are read/write RAM. Every other page is unmapped: a read from it must return all-ones, and a write to it is dropped.

Software writes and reads back the page registers through four I/O ports. The unit also decodes a sixteen-port window that belongs to the video chip. A write to that window raises a strobe and gives the register index. The memory arrays, the other peripherals and the CPU are outside this block.

Top module: `mem_page_unit`

## Requirements
- R1: During a memory access, `phys_addr` is {page register of slot `cpu_addr[15:14]`, `cpu_addr[13:0]`}. The 8-bit page number forms bits 21:14.
- R2: An I/O write to port 0xB0+n (n = 0..3) loads `cpu_wdata` into the page register of slot n. An I/O read from that port raises `io_hit` and shows the register on `io_rdata`. Only `cpu_addr[7:0]` is decoded for ports. On any other read, `io_hit` is 0 and `io_rdata` is 0xFF.
- R3: After reset, all four page registers hold 0, so ROM page 0 appears in every slot.
- R4: For a page value below 2, a memory read asserts `rom_cs`. A memory write to such a slot asserts neither `rom_cs`, `ram_cs` nor `ram_we`.
- R5: For a page value from 0xFC to 0xFF, a memory read or write asserts `ram_cs`. `ram_we` is asserted only on the write.
- R6: For any other page value, a memory read asserts `bus_ff`, which tells the data path to return 0xFF. A memory write asserts none of `rom_cs`, `ram_cs` or `ram_we`.
- R7: An I/O write to a port from 0x80 to 0x8F asserts `vid_wr` in that cycle, with `vid_reg` = port bits 3:0. No other access asserts `vid_wr`.
- R8: A page register write changes the mapping for memory accesses in the clock cycle after the I/O write, and not before.
- R9: At most one of `rom_cs`, `ram_cs` and `bus_ff` is high at a time. All three, and `ram_we`, are low when there is no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address; the low 8 bits are the I/O port |
| cpu_wdata | input | 8 | CPU write data |
| mem_rd | input | 1 | Memory read cycle |
| mem_wr | input | 1 | Memory write cycle |
| io_rd | input | 1 | I/O read cycle |
| io_wr | input | 1 | I/O write cycle |
| phys_addr | output | 22 | Physical memory address |
| rom_cs | output | 1 | ROM select (reads only) |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| bus_ff | output | 1 | Unmapped read: drive 0xFF onto the data bus |
| io_hit | output | 1 | I/O read hit a page register port |
| io_rdata | output | 8 | I/O read data |
| vid_wr | output | 1 | Video register write strobe |
| vid_reg | output | 4 | Video register index |

## Verification
The assertions assume that the CPU raises at most one of `mem_rd`, `mem_wr`, `io_rd` and `io_wr` in a cycle, because the address bus is shared between memory and I/O. The bench keeps to this by choosing exactly one access kind per cycle, or none. Page values are drawn with weight on the edges between regions: 0, 1, 2, 0xFB and 0xFC to 0xFF. The bench also issues I/O accesses with random upper address bits, to show that those bits are ignored.

// File: rtl/mem_page_unit.sv
module mem_page_unit #(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 14,
  parameter int PAGE_W    = 8,
  parameter int ROM_PAGES = 2,
  parameter int RAM_PAGES = 4,
  parameter int VREG_W    = 4,
  parameter logic [7:0] PAGE_PORT = 8'hB0,
  parameter logic [7:0] VID_PORT  = 8'h80
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [PAGE_W-1:0]         cpu_wdata,
  input  logic                      mem_rd,
  input  logic                      mem_wr,
  input  logic                      io_rd,
  input  logic                      io_wr,
  output logic [PAGE_W+OFF_W-1:0]   phys_addr,
  output logic                      rom_cs,
  output logic                      ram_cs,
  output logic                      ram_we,
  output logic                      bus_ff,
  output logic                      io_hit,
  output logic [PAGE_W-1:0]         io_rdata,
  output logic                      vid_wr,
  output logic [VREG_W-1:0]         vid_reg
);
  localparam int SLOT_W = ADDR_W - OFF_W;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam logic [PAGE_W-1:0] ROM_LIM = PAGE_W'(ROM_PAGES);
  localparam logic [PAGE_W-1:0] RAM_LO  = PAGE_W'((1 << PAGE_W) - RAM_PAGES);

  logic [PAGE_W-1:0] page_q [NSLOT];
  logic [7:0]        port;
  logic [SLOT_W-1:0] port_slot, mem_slot;
  logic              page_port, page_wr;
  logic [PAGE_W-1:0] cur_page;
  logic              is_rom, is_ram, is_open, mem_acc;

  assign port      = cpu_addr[7:0];
  assign port_slot = port[SLOT_W-1:0];
  assign page_port = port[7:SLOT_W] == PAGE_PORT[7:SLOT_W];
  assign page_wr   = io_wr & page_port;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        page_q[s] <= '0;
      else if (page_wr && port_slot == SLOT_W'(s))
        page_q[s] <= cpu_wdata;
    end
  end

  assign mem_slot  = cpu_addr[ADDR_W-1:OFF_W];
  assign cur_page  = page_q[mem_slot];
  assign phys_addr = {cur_page, cpu_addr[OFF_W-1:0]};

  assign is_rom  = cur_page < ROM_LIM;
  assign is_ram  = cur_page >= RAM_LO;
  assign is_open = !is_rom && !is_ram;
  assign mem_acc = mem_rd | mem_wr;

  assign rom_cs = mem_rd  & is_rom;
  assign ram_cs = mem_acc & is_ram;
  assign ram_we = mem_wr  & is_ram;
  assign bus_ff = mem_rd  & is_open;

  assign io_hit   = io_rd & page_port;
  assign io_rdata = io_hit ? page_q[port_slot] : '1;

  assign vid_wr  = io_wr & (port[7:VREG_W] == VID_PORT[7:VREG_W]);
  assign vid_reg = port[VREG_W-1:0];

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs, bus_ff}));

  // R5
  we_needs_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_cs && mem_wr);

  // R4
  rom_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> mem_rd && !ram_we);

  // R7
  vid_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_wr |-> io_wr && !ram_we && !rom_cs);

  // R8
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr |=> page_q[$past(port_slot)] == $past(cpu_wdata));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd || mem_wr) |-> !(rom_cs || ram_cs || ram_we || bus_ff));
endmodule

// File: tb/tb_mem_page_unit.sv
`timescale 1ns/1ps
module tb_mem_page_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        mem_rd, mem_wr, io_rd, io_wr;
  logic [21:0] phys_addr;
  logic        rom_cs, ram_cs, ram_we, bus_ff, io_hit, vid_wr;
  logic [7:0]  io_rdata;
  logic [3:0]  vid_reg;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  logic [7:0] pages [4];

  always #10 clk = ~clk;

  mem_page_unit dut (.*);

  function automatic int kind_of(input logic [7:0] p);
    if (p <= 8'd1) return 0;
    if (p >= 8'hFC) return 1;
    return 2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic mr, input logic mw, input logic ir, input logic iw,
                      input logic [15:0] a, input logic [7:0] d);
    logic [7:0] pg;
    int k;
    bit pp, vp;
    mem_rd = mr; mem_wr = mw; io_rd = ir; io_wr = iw;
    cpu_addr = a; cpu_wdata = d;
    #5;
    pg = pages[a[15:14]];
    k  = kind_of(pg);
    pp = a[7:2] == 6'b101100;
    vp = a[7:4] == 4'h8;
    if (mr || mw)
      chk(phys_addr == {pg, a[13:0]}, "R1", phys_addr, {pg, a[13:0]});
    chk(rom_cs == (mr && k == 0), "R4", rom_cs, mr && k == 0);
    chk(ram_cs == ((mr || mw) && k == 1), "R5", ram_cs, (mr || mw) && k == 1);
    chk(ram_we == (mw && k == 1), "R5", ram_we, mw && k == 1);
    chk(bus_ff == (mr && k == 2), "R6", bus_ff, mr && k == 2);
    if (!(mr || mw))
      chk(!(rom_cs || ram_cs || ram_we || bus_ff), "R9", {rom_cs, ram_cs, ram_we, bus_ff}, 0);
    if (ir) begin
      chk(io_hit == pp, "R2", io_hit, pp);
      chk(io_rdata == (pp ? pages[a[1:0]] : 8'hFF), "R2", io_rdata, pp ? pages[a[1:0]] : 8'hFF);
    end
    chk(vid_wr == (iw && vp), "R7", vid_wr, iw && vp);
    if (iw && vp)
      chk(vid_reg == a[3:0], "R7", vid_reg, a[3:0]);
    @(posedge clk);
    if (iw && pp) pages[a[1:0]] = d;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pick_page();
    case ($urandom % 6)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'hFC + 8'($urandom % 4);
      3: return 8'($urandom);
      4: return 8'h02;
      default: return 8'hFB;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    {mem_rd, mem_wr, io_rd, io_wr} = '0;
    cpu_addr = '0; cpu_wdata = '0;
    for (int i = 0; i < 4; i++) pages[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: every slot reads back 0 and shows ROM page 0
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 16'h00B0 + 16'(i), 8'h00);
    step(1, 0, 0, 0, 16'hC123, 8'h00);
    chk(pages[3] == 8'h00, "R3", pages[3], 0);

    // R2: upper port bits ignored
    step(0, 0, 0, 1, 16'h12B2, 8'hFE);
    step(0, 0, 1, 0, 16'hFFB2, 8'h00);
    step(0, 0, 1, 0, 16'h00B7, 8'h00);

    // R8: mapping changes on the very next cycle
    step(1, 0, 0, 0, 16'h4123, 8'h00);
    step(0, 0, 0, 1, 16'h00B1, 8'hFD);
    step(0, 1, 0, 0, 16'h4123, 8'h5A);

    // R4: write to ROM slot ignored, R6: unmapped page
    step(0, 1, 0, 0, 16'h0010, 8'h11);
    step(0, 0, 0, 1, 16'h00B0, 8'h40);
    step(1, 0, 0, 0, 16'h0010, 8'h00);
    step(0, 1, 0, 0, 16'h0010, 8'h22);
    step(0, 0, 0, 1, 16'h00B0, 8'hFB);
    step(1, 0, 0, 0, 16'h3FFF, 8'h00);

    // R7: video window edges
    step(0, 0, 0, 1, 16'h338F, 8'h77);
    step(0, 0, 0, 1, 16'h0080, 8'h01);
    step(0, 0, 0, 1, 16'h0090, 8'h01);
    step(0, 0, 0, 1, 16'h007F, 8'h01);

    // R9: idle
    step(0, 0, 0, 0, 16'hFFFF, 8'hFF);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      case ($urandom % 7)
        0: step(1, 0, 0, 0, a, 8'h00);
        1: step(0, 1, 0, 0, a, 8'($urandom));
        2: step(0, 0, 0, 1, {a[15:8], 6'b101100, a[1:0]}, pick_page());
        3: step(0, 0, 1, 0, {a[15:8], 6'b101100, a[1:0]}, 8'h00);
        4: step(0, 0, 0, 1, {a[15:8], 4'h8, a[3:0]}, 8'($urandom));
        5: step(0, 0, 1, 0, a, 8'h00);
        default: step(0, 0, 0, 0, a, 8'h00);
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule